// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a flash-style memory. It watches each bus write cycle, an address plus a 16-bit data word, and turns the stream of writes into operation requests. Some commands take effect in one write. Others need a setup write followed by one or two more writes. The command code always comes from the low byte of the write data. The block does not model the array, the status register contents or the embedded program and erase algorithms. It only reports what was asked for.

It has two kinds of output. The first is a registered read mode, which tells the read path whether to return array data, the status register, the electronic signature or the query table. The second is a one-hot vector of single-cycle operation strobes. Each strobe comes with the address and data of the write that completed the sequence. A double-word program also reports the address and data of its first data write. A sequence that is malformed raises a one-cycle error flag, drops the sequence and returns the read mode to array.

The sequencer has seven states:
- `S_IDLE` waits for a first-cycle code.
- `S_PROG` waits for the program data write.
- `S_ERASE` waits for the erase confirm.
- `S_DW1` waits for the first double-word data write.
- `S_DW2` waits for the second double-word data write.
- `S_LOCK` waits for the lock-group selector.
- `S_PROT` waits for the protection-register data write.

The transitions are:
- `S_IDLE` moves to `S_ERASE` on 20h, to `S_PROG` on 40h or 10h, to `S_DW1` on 30h, to `S_LOCK` on 60h and to `S_PROT` on C0h. Every other code leaves it in `S_IDLE`.
- `S_DW1` moves to `S_DW2` and captures the first address and data.
- Every other waiting state returns to `S_IDLE` on its next write, either firing a strobe or flagging an error.
- A cycle with no write never changes the state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (encoding 0), all bits of `op_strobe` are 0, `seq_err` is 0, and the sequencer waits for a first-cycle code.
- R2: A single write whose low data byte is FFh, 70h or 90h sets the read mode to array (0), status (1) or signature (2). The upper data byte is ignored.
- R3: Writing 98h at address 55h sets the read mode to query (3). Writing 98h at any other address is a sequence error.
- R4: The single-write codes 50h, B0h and D0h (D0h only when no sequence is pending) pulse `op_strobe` bit 3 (clear status), bit 4 (suspend) and bit 5 (resume).
- R5: 20h followed by a write with low byte D0h pulses bit 0 (erase). Any other second code is a sequence error, and no strobe fires.
- R6: 40h or 10h followed by any write pulses bit 1 (program) with that write's address and data.
- R7: 30h followed by two writes whose addresses differ only in bit 0 pulses bit 2 (double-word program). `op_addr`/`op_data` carry the second write, and `op_addr_first`/`op_data_first` carry the first. Any other address pair is a sequence error.
- R8: 60h followed by a write with low byte 01h, D0h or 2Fh pulses bit 6 (lock), bit 7 (unlock) or bit 8 (lock-down). Any other code is a sequence error.
- R9: C0h followed by any write pulses bit 9 (protection register program).
- R10: A first-cycle code that is not part of the command set is a sequence error.
- R11: A strobe appears in the cycle after the write that completes the sequence. It is exactly one cycle wide, at most one bit is set at a time, and `op_addr`/`op_data` equal that write's address and data. `seq_err` is likewise a one-cycle pulse and never coincides with a strobe.
- R12: Cycles without `wr_en` change neither the sequencer nor the read mode, so a sequence may pause between its writes.
- R13: Multi-cycle commands leave the read mode unchanged. A sequence error forces it to array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte holds the command code |
| read_mode | output | 2 | 0 array, 1 status, 2 signature, 3 query |
| op_strobe | output | 10 | One-hot operation pulse, bit order as in R4–R9 |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| op_addr_first | output | ADDR_W | First data-write address of a double-word program |
| op_data_first | output | DATA_W | First data-write data of a double-word program |
| seq_err | output | 1 | One-cycle malformed-sequence pulse |

## Verification
A wrong internal state shows up at the ports on the very next write. If the state is stuck in a waiting state, the next first-cycle code is taken as second-cycle data: a spurious strobe or `seq_err` appears one cycle after that write, instead of the expected read-mode change. If the state wrongly returns to idle, a valid confirm write is decoded as a fresh command, so the erase confirm D0h shows up as a resume strobe. The directed tests place each sequence after other commands and after idle gaps, so these slips show within one cycle of the misread write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_ERASE,
        S_DW1,
        S_DW2,
        S_LOCK,
        S_PROT
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_SIGN   = 2'd2,
        RM_QUERY  = 2'd3
    } rd_mode_t;

    typedef enum logic [3:0] {
        K_RD_ARRAY,
        K_RD_STATUS,
        K_RD_SIGN,
        K_RD_QUERY,
        K_CLR,
        K_SUSP,
        K_RESUME,
        K_ERASE_SU,
        K_PROG_SU,
        K_DW_SU,
        K_LOCK_SU,
        K_PROT_SU,
        K_BAD
    } first_kind_t;

    localparam int NUM_OPS = 10;
    localparam int OP_W    = 4;

    localparam logic [OP_W-1:0] OP_ERASE    = 4'd0;
    localparam logic [OP_W-1:0] OP_PROG     = 4'd1;
    localparam logic [OP_W-1:0] OP_DWPROG   = 4'd2;
    localparam logic [OP_W-1:0] OP_CLRSTAT  = 4'd3;
    localparam logic [OP_W-1:0] OP_SUSPEND  = 4'd4;
    localparam logic [OP_W-1:0] OP_RESUME   = 4'd5;
    localparam logic [OP_W-1:0] OP_LOCK     = 4'd6;
    localparam logic [OP_W-1:0] OP_UNLOCK   = 4'd7;
    localparam logic [OP_W-1:0] OP_LOCKDOWN = 4'd8;
    localparam logic [OP_W-1:0] OP_PROTPROG = 4'd9;

    localparam logic [7:0] CODE_ARRAY   = 8'hFF;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_SIGN    = 8'h90;
    localparam logic [7:0] CODE_QUERY   = 8'h98;
    localparam logic [7:0] CODE_CLR     = 8'h50;
    localparam logic [7:0] CODE_SUSP    = 8'hB0;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;
    localparam logic [7:0] CODE_ERASE   = 8'h20;
    localparam logic [7:0] CODE_PROG_A  = 8'h40;
    localparam logic [7:0] CODE_PROG_B  = 8'h10;
    localparam logic [7:0] CODE_DW      = 8'h30;
    localparam logic [7:0] CODE_LOCKGRP = 8'h60;
    localparam logic [7:0] CODE_LOCKSET = 8'h01;
    localparam logic [7:0] CODE_LOCKDN  = 8'h2F;
    localparam logic [7:0] CODE_PROT    = 8'hC0;

    localparam int QUERY_ADDR = 'h55;

endpackage

// File: rtl/fcd_code_class.sv
module fcd_code_class
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [7:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output first_kind_t       kind
);

    localparam logic [ADDR_W-1:0] QADDR = ADDR_W'(QUERY_ADDR);

    always_comb begin
        unique case (code)
            CODE_ARRAY:   kind = K_RD_ARRAY;
            CODE_STATUS:  kind = K_RD_STATUS;
            CODE_SIGN:    kind = K_RD_SIGN;
            CODE_QUERY:   kind = (addr == QADDR) ? K_RD_QUERY : K_BAD;
            CODE_CLR:     kind = K_CLR;
            CODE_SUSP:    kind = K_SUSP;
            CODE_CONFIRM: kind = K_RESUME;
            CODE_ERASE:   kind = K_ERASE_SU;
            CODE_PROG_A,
            CODE_PROG_B:  kind = K_PROG_SU;
            CODE_DW:      kind = K_DW_SU;
            CODE_LOCKGRP: kind = K_LOCK_SU;
            CODE_PROT:    kind = K_PROT_SU;
            default:      kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  first_kind_t       kind,
    output logic              req_fire,
    output logic [OP_W-1:0]   req_op,
    output logic              req_err,
    output logic              req_mode_set,
    output rd_mode_t          req_mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [DATA_W-1:0] first_data
);

    localparam logic [ADDR_W-1:0] PAIR_DIFF = ADDR_W'(1);

    seq_state_t state_q, state_d;
    logic       cap_first;
    logic [7:0] code;

    assign code = wr_data[7:0];

    // state register and first-write capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            first_addr <= '0;
            first_data <= '0;
        end else begin
            state_q <= state_d;
            if (cap_first) begin
                first_addr <= wr_addr;
                first_data <= wr_data;
            end
        end
    end

    // next state and requests
    always_comb begin
        state_d      = state_q;
        req_fire     = 1'b0;
        req_op       = OP_ERASE;
        req_err      = 1'b0;
        req_mode_set = 1'b0;
        req_mode     = RM_ARRAY;
        cap_first    = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                S_IDLE: begin
                    unique case (kind)
                        K_RD_ARRAY:  begin req_mode_set = 1'b1; req_mode = RM_ARRAY;  end
                        K_RD_STATUS: begin req_mode_set = 1'b1; req_mode = RM_STATUS; end
                        K_RD_SIGN:   begin req_mode_set = 1'b1; req_mode = RM_SIGN;   end
                        K_RD_QUERY:  begin req_mode_set = 1'b1; req_mode = RM_QUERY;  end
                        K_CLR:       begin req_fire = 1'b1; req_op = OP_CLRSTAT; end
                        K_SUSP:      begin req_fire = 1'b1; req_op = OP_SUSPEND; end
                        K_RESUME:    begin req_fire = 1'b1; req_op = OP_RESUME;  end
                        K_ERASE_SU:  state_d = S_ERASE;
                        K_PROG_SU:   state_d = S_PROG;
                        K_DW_SU:     state_d = S_DW1;
                        K_LOCK_SU:   state_d = S_LOCK;
                        K_PROT_SU:   state_d = S_PROT;
                        default:     req_err = 1'b1;
                    endcase
                end
                S_ERASE: begin
                    state_d = S_IDLE;
                    if (code == CODE_CONFIRM) begin
                        req_fire = 1'b1;
                        req_op   = OP_ERASE;
                    end else begin
                        req_err = 1'b1;
                    end
                end
                S_PROG: begin
                    state_d  = S_IDLE;
                    req_fire = 1'b1;
                    req_op   = OP_PROG;
                end
                S_DW1: begin
                    state_d   = S_DW2;
                    cap_first = 1'b1;
                end
                S_DW2: begin
                    state_d = S_IDLE;
                    if ((wr_addr ^ first_addr) == PAIR_DIFF) begin
                        req_fire = 1'b1;
                        req_op   = OP_DWPROG;
                    end else begin
                        req_err = 1'b1;
                    end
                end
                S_LOCK: begin
                    state_d = S_IDLE;
                    unique case (code)
                        CODE_LOCKSET: begin req_fire = 1'b1; req_op = OP_LOCK;     end
                        CODE_CONFIRM: begin req_fire = 1'b1; req_op = OP_UNLOCK;   end
                        CODE_LOCKDN:  begin req_fire = 1'b1; req_op = OP_LOCKDOWN; end
                        default:      req_err = 1'b1;
                    endcase
                end
                S_PROT: begin
                    state_d  = S_IDLE;
                    req_fire = 1'b1;
                    req_op   = OP_PROTPROG;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcd_out_regs.sv
module fcd_out_regs
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_fire,
    input  logic [OP_W-1:0]    req_op,
    input  logic               req_err,
    input  logic               req_mode_set,
    input  rd_mode_t           req_mode,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  first_addr,
    input  logic [DATA_W-1:0]  first_data,
    output logic [1:0]         read_mode,
    output logic [NUM_OPS-1:0] op_strobe,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [DATA_W-1:0]  op_data,
    output logic [ADDR_W-1:0]  op_addr_first,
    output logic [DATA_W-1:0]  op_data_first,
    output logic               seq_err
);

    rd_mode_t mode_q;
    assign read_mode = mode_q;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (!rst_n) op_strobe[g] <= 1'b0;
            else        op_strobe[g] <= req_fire && (req_op == OP_W'(g));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= RM_ARRAY;
            seq_err       <= 1'b0;
            op_addr       <= '0;
            op_data       <= '0;
            op_addr_first <= '0;
            op_data_first <= '0;
        end else begin
            seq_err <= req_err;
            if (req_err)           mode_q <= RM_ARRAY;
            else if (req_mode_set) mode_q <= req_mode;
            if (req_fire) begin
                op_addr       <= wr_addr;
                op_data       <= wr_data;
                op_addr_first <= first_addr;
                op_data_first <= first_data;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [1:0]         read_mode,
    output logic [NUM_OPS-1:0] op_strobe,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [DATA_W-1:0]  op_data,
    output logic [ADDR_W-1:0]  op_addr_first,
    output logic [DATA_W-1:0]  op_data_first,
    output logic               seq_err
);

    first_kind_t       kind;
    logic              req_fire;
    logic [OP_W-1:0]   req_op;
    logic              req_err;
    logic              req_mode_set;
    rd_mode_t          req_mode;
    logic [ADDR_W-1:0] first_addr;
    logic [DATA_W-1:0] first_data;

    fcd_code_class #(.ADDR_W(ADDR_W)) u_class (
        .code (wr_data[7:0]),
        .addr (wr_addr),
        .kind (kind)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .kind         (kind),
        .req_fire     (req_fire),
        .req_op       (req_op),
        .req_err      (req_err),
        .req_mode_set (req_mode_set),
        .req_mode     (req_mode),
        .first_addr   (first_addr),
        .first_data   (first_data)
    );

    fcd_out_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_fire      (req_fire),
        .req_op        (req_op),
        .req_err       (req_err),
        .req_mode_set  (req_mode_set),
        .req_mode      (req_mode),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .first_addr    (first_addr),
        .first_data    (first_data),
        .read_mode     (read_mode),
        .op_strobe     (op_strobe),
        .op_addr       (op_addr),
        .op_data       (op_data),
        .op_addr_first (op_addr_first),
        .op_data_first (op_data_first),
        .seq_err       (seq_err)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [1:0]         read_mode,
    input logic [NUM_OPS-1:0] op_strobe,
    input logic [ADDR_W-1:0]  op_addr,
    input logic [DATA_W-1:0]  op_data,
    input logic [ADDR_W-1:0]  op_addr_first,
    input logic               seq_err
);

    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_strobe));

    assert_strobe_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe != '0) |-> $past(wr_en));

    assert_strobe_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe != '0) |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

    assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (op_strobe == '0));

    assert_err_array_R13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (read_mode == 2'd0));

    assert_idle_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (read_mode == $past(read_mode) && op_strobe == '0 && !seq_err));

    assert_erase_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_strobe[0] |-> (op_data[7:0] == 8'hD0));

    assert_dw_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_strobe[2] |-> ((op_addr ^ op_addr_first) == ADDR_W'(1)));

    assert_lock_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_strobe[6] |-> (op_data[7:0] == 8'h01));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .read_mode     (read_mode),
    .op_strobe     (op_strobe),
    .op_addr       (op_addr),
    .op_data       (op_data),
    .op_addr_first (op_addr_first),
    .seq_err       (seq_err)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    read_mode;
    logic [9:0]    op_strobe;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [AW-1:0] op_addr_first;
    logic [DW-1:0] op_data_first;
    logic          seq_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .read_mode(read_mode), .op_strobe(op_strobe), .op_addr(op_addr), .op_data(op_data),
        .op_addr_first(op_addr_first), .op_data_first(op_data_first), .seq_err(seq_err)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one write cycle; returns at the next falling edge, where registered results are visible
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_op(input string req, input int bitn, input logic [AW-1:0] a, input logic [DW-1:0] d);
        check(req, "strobe", 32'(op_strobe), 32'(10'b1 << bitn));
        check(req, "addr", 32'(op_addr), 32'(a));
        check(req, "data", 32'(op_data), 32'(d));
        check(req, "err", 32'(seq_err), 32'd0);
    endtask

    task automatic expect_err(input string req);
        check(req, "err", 32'(seq_err), 32'd1);
        check(req, "strobe", 32'(op_strobe), 32'd0);
        check(req, "mode", 32'(read_mode), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1", "mode", 32'(read_mode), 32'd0);
        check("R1", "strobe", 32'(op_strobe), 32'd0);
        check("R1", "err", 32'(seq_err), 32'd0);
    endtask

    task automatic t_read_modes();
        wr(22'h0, 16'h0070); check("R2", "status", 32'(read_mode), 32'd1);
        wr(22'h3, 16'hAB90); check("R2", "sign hi byte", 32'(read_mode), 32'd2);
        check("R2", "no strobe", 32'(op_strobe), 32'd0);
        wr(22'h7, 16'h00FF); check("R2", "array", 32'(read_mode), 32'd0);
    endtask

    task automatic t_query();
        wr(22'h55, 16'h0098); check("R3", "query", 32'(read_mode), 32'd3);
        wr(22'h56, 16'h0098); expect_err("R3");
    endtask

    task automatic t_single();
        wr(22'h11, 16'h0050); expect_op("R4", 3, 22'h11, 16'h0050);
        wr(22'h12, 16'h00B0); expect_op("R4", 4, 22'h12, 16'h00B0);
        wr(22'h13, 16'h00D0); expect_op("R4", 5, 22'h13, 16'h00D0);
        idle(1); check("R11", "one wide", 32'(op_strobe), 32'd0);
    endtask

    task automatic t_erase();
        wr(22'h0, 16'h0020); check("R5", "setup quiet", 32'(op_strobe), 32'd0);
        wr(22'h2A000, 16'h00D0); expect_op("R5", 0, 22'h2A000, 16'h00D0);
        wr(22'h0, 16'h0020);
        wr(22'h2A000, 16'h00D1); expect_err("R5");
        wr(22'h5, 16'h00D0); expect_op("R5", 5, 22'h5, 16'h00D0);
    endtask

    task automatic t_program();
        wr(22'h0, 16'h0040);
        wr(22'h1234, 16'hBEEF); expect_op("R6", 1, 22'h1234, 16'hBEEF);
        wr(22'h0, 16'h0010);
        wr(22'h3FFFFF, 16'h00FF); expect_op("R6", 1, 22'h3FFFFF, 16'h00FF);
        check("R13", "mode kept", 32'(read_mode), 32'd0);
    endtask

    task automatic t_dword();
        wr(22'h0, 16'h0030);
        wr(22'h100, 16'h1111); check("R7", "mid quiet", 32'(op_strobe), 32'd0);
        wr(22'h101, 16'h2222); expect_op("R7", 2, 22'h101, 16'h2222);
        check("R7", "first addr", 32'(op_addr_first), 32'h100);
        check("R7", "first data", 32'(op_data_first), 32'h1111);
        wr(22'h0, 16'h0030);
        wr(22'h201, 16'h3333);
        wr(22'h200, 16'h4444); expect_op("R7", 2, 22'h200, 16'h4444);
        check("R7", "first rev", 32'(op_addr_first), 32'h201);
        wr(22'h0, 16'h0030);
        wr(22'h100, 16'h5555);
        wr(22'h102, 16'h6666); expect_err("R7");
    endtask

    task automatic t_lock();
        wr(22'h0, 16'h0060); wr(22'h8000, 16'h0001); expect_op("R8", 6, 22'h8000, 16'h0001);
        wr(22'h0, 16'h0060); wr(22'h9000, 16'h00D0); expect_op("R8", 7, 22'h9000, 16'h00D0);
        wr(22'h0, 16'h0060); wr(22'hA000, 16'h002F); expect_op("R8", 8, 22'hA000, 16'h002F);
        wr(22'h0, 16'h0070);
        wr(22'h0, 16'h0060); wr(22'hA000, 16'h0002); expect_err("R8");
    endtask

    task automatic t_prot();
        wr(22'h0, 16'h00C0);
        wr(22'h81, 16'hCAFE); expect_op("R9", 9, 22'h81, 16'hCAFE);
    endtask

    task automatic t_unknown();
        wr(22'h0, 16'h0070);
        wr(22'h0, 16'h00AA); expect_err("R10");
        wr(22'h0, 16'h0050); expect_op("R10", 3, 22'h0, 16'h0050);
    endtask

    task automatic t_gap();
        wr(22'h0, 16'h0070);
        wr(22'h0, 16'h0020);
        idle(5);
        check("R12", "mode held", 32'(read_mode), 32'd1);
        check("R12", "no strobe", 32'(op_strobe), 32'd0);
        wr(22'h4000, 16'h00D0); expect_op("R12", 0, 22'h4000, 16'h00D0);
        check("R13", "status kept", 32'(read_mode), 32'd1);
        idle(1);
        check("R11", "strobe cleared", 32'(op_strobe), 32'd0);
        check("R11", "err cleared", 32'(seq_err), 32'd0);
    endtask

    initial begin
        t_reset();
        t_read_modes();
        t_query();
        t_single();
        t_erase();
        t_program();
        t_dword();
        t_lock();
        t_prot();
        t_unknown();
        t_gap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule